// File: doc/BRIEF.md
# Maskable Interrupt Controller with Wake

The block collects a vector of level interrupt inputs and reports them to a processor core. A line counts as asserting when its input goes from low to high. On that event the line is latched into a status register if software has unmasked it, or if it is one of the low-numbered lines that ignore the mask. Any latch raises an exception request toward the core. The request is sent in the latch cycle when the core's interrupt-enable flag is set. Otherwise it is held pending and checked again on every clock until the flag comes up.

Every asserting line produces a one-cycle wake pulse, whether it is masked or not. The power-management logic uses that pulse to drop its doze and sleep enables. Software reaches three registers through a small word port: mask, priority and status. Status bits are cleared by writing zeros. The priority register is plain storage and does not affect delivery.

Top module: `intc_wake_top`

## Requirements
- R1: While reset is low and after it is released, the mask, priority and status registers read zero, and both exc_req and pm_clear are low.
- R2: reg_addr selects mask at 0, priority at 1 and status at 2. reg_rdata follows reg_addr combinationally. Address 3 reads zero, and a write to it changes no register.
- R3: A line is detected once per low-to-high transition. The line's status bit reads one after the second rising clock edge that samples the input high. A line held high does not latch again after software clears its bit.
- R4: A detected line sets its status bit only when its mask bit (bit i for line i) is one or its index is below NUM_BYPASS (default 2, so lines 0 and 1).
- R5: Every detected line, masked or not, drives pm_clear high for exactly the one cycle between the first and second edges that sample it high.
- R6: When a line latches while ie_flag is high, exc_req is high in that same cycle, and for that cycle only.
- R7: When a line latches while ie_flag is low, exc_req stays low. The request stays pending. exc_req rises in the first cycle that ie_flag is high and is low on the following cycle.
- R8: A write to status keeps the bits written as one and clears the bits written as zero; it can never set a bit. A line that latches at the same edge as the write keeps its bit set.
- R9: A status write that leaves every status bit zero cancels a pending request, so a later rise of ie_flag produces no exc_req.
- R10: The priority register reads back what was written and has no effect on latching or on exc_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 32 | Interrupt inputs, one per line |
| ie_flag | input | 1 | Processor interrupt-enable flag |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| exc_req | output | 1 | External-interrupt exception request pulse |
| pm_clear | output | 1 | Pulse that clears doze and sleep enables |

## Verification
The assertions assume that irq_lines and ie_flag are synchronous to clk and change only between edges. They also assume the register port is used by a single master with no read side effects. The bench drives every input on the falling edge and holds it for at least one full cycle. It leaves a line low for several cycles before raising it again, so each transition is a clean edge for the detector. It mixes ie_flag levels, mask patterns and same-edge status writes, so that both the pending path and the path that delivers immediately are reached.

// File: rtl/intc_pkg.sv
// Package: shared register address encoding for the interrupt controller.
// Assumes a two-bit register select on the software port.
package intc_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_MASK = 2'd0,
        RA_PRIO = 2'd1,
        RA_STAT = 2'd2,
        RA_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/intc_edge.sv
// Module: intc_edge
// Registers each interrupt input once and keeps one cycle of history, then
// flags a low-to-high change per line. Assumes inputs are synchronous to clk.
module intc_edge #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines_in,
    output logic [NUM_LINES-1:0] rise
);
    logic [NUM_LINES-1:0] samp_q;
    logic [NUM_LINES-1:0] hist_q;

    // Sample the inputs and keep the prior sample for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= '0;
            hist_q <= '0;
        end else begin
            samp_q <= lines_in;
            hist_q <= samp_q;
        end
    end

    // A rise is a line that is high now and was low one sample earlier.
    always_comb rise = samp_q & ~hist_q;
endmodule

// File: rtl/intc_regs.sv
// Module: intc_regs
// Holds the mask, priority and status registers with the software read/write
// port. Applies the mask (with a bypass for the lowest lines) to detected rises
// and reports any latch plus a software clear of the whole status register.
// Assumes one write per cycle and reads without side effects.
module intc_regs
    import intc_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int NUM_BYPASS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] rise,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] rdata,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] status_q,
    output logic                 any_latch,
    output logic                 sw_clear_all
);
    logic [NUM_LINES-1:0] prio_q;
    logic [NUM_LINES-1:0] line_en;
    logic [NUM_LINES-1:0] latch_vec;
    logic [NUM_LINES-1:0] kept;
    logic [NUM_LINES-1:0] status_d;
    reg_addr_e            sel;

    always_comb sel = reg_addr_e'(addr);

    // Per-line enable: bypass lines ignore the mask.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_en
        if (i < NUM_BYPASS) begin : g_byp
            assign line_en[i] = 1'b1;
        end else begin : g_msk
            assign line_en[i] = mask_q[i];
        end
    end

    // Lines that latch this cycle and the software-kept status bits.
    always_comb begin
        latch_vec = rise & line_en;
        any_latch = |latch_vec;
        kept      = (we && sel == RA_STAT) ? (status_q & wdata) : status_q;
        status_d  = kept | latch_vec;
        sw_clear_all = we && (sel == RA_STAT) && (kept == '0);
    end

    // Register state update for mask, priority and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            prio_q   <= '0;
            status_q <= '0;
        end else begin
            if (we && sel == RA_MASK) mask_q <= wdata;
            if (we && sel == RA_PRIO) prio_q <= wdata;
            status_q <= status_d;
        end
    end

    // Combinational read mux; the unused address reads zero.
    always_comb begin
        unique case (sel)
            RA_MASK: rdata = mask_q;
            RA_PRIO: rdata = prio_q;
            RA_STAT: rdata = status_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/intc_deliver.sv
// Module: intc_deliver
// Turns latch events into exception request pulses. A latch seen while the
// core's enable is low is held pending and retried each cycle. Assumes ie is
// synchronous to clk.
module intc_deliver (
    input  logic clk,
    input  logic rst_n,
    input  logic any_latch,
    input  logic ie,
    input  logic sw_clear_all,
    output logic pending_q,
    output logic req
);
    logic pending_d;

    // Request now if enabled and either a fresh latch or an older pending one.
    always_comb begin
        req = ie && (any_latch || pending_q);
        if (any_latch && !ie)
            pending_d = 1'b1;
        else if (ie || sw_clear_all)
            pending_d = 1'b0;
        else
            pending_d = pending_q;
    end

    // Pending flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) pending_q <= 1'b0;
        else        pending_q <= pending_d;
    end
endmodule

// File: rtl/intc_wake_top.sv
// Module: intc_wake_top
// Interrupt controller top: edge capture, mask/status registers, exception
// request delivery and the wake pulse to power management. Assumes all inputs
// are synchronous to clk; reset is synchronous and active low.
module intc_wake_top
    import intc_pkg::*;
#(
    parameter int NUM_LINES  = 32,
    parameter int NUM_BYPASS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 ie_flag,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [NUM_LINES-1:0] reg_wdata,
    output logic [NUM_LINES-1:0] reg_rdata,
    output logic                 exc_req,
    output logic                 pm_clear
);
    logic [NUM_LINES-1:0] rise;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] status_q;
    logic                 any_latch;
    logic                 sw_clear_all;
    logic                 pending_q;

    intc_edge #(.NUM_LINES(NUM_LINES)) u_edge (
        .clk(clk), .rst_n(rst_n), .lines_in(irq_lines), .rise(rise)
    );

    intc_regs #(.NUM_LINES(NUM_LINES), .NUM_BYPASS(NUM_BYPASS)) u_regs (
        .clk(clk), .rst_n(rst_n), .rise(rise), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .mask_q(mask_q),
        .status_q(status_q), .any_latch(any_latch), .sw_clear_all(sw_clear_all)
    );

    intc_deliver u_dlv (
        .clk(clk), .rst_n(rst_n), .any_latch(any_latch), .ie(ie_flag),
        .sw_clear_all(sw_clear_all), .pending_q(pending_q), .req(exc_req)
    );

    // Wake pulse on any detected rise, masked or not.
    always_comb pm_clear = |rise;
endmodule

// File: rtl/intc_wake_chk.sv
// Module: intc_wake_chk
// Assertion checker bound to intc_wake_top. Assumes synchronous inputs.
module intc_wake_chk #(
    parameter int NUM_LINES  = 32,
    parameter int NUM_BYPASS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic                 ie_flag,
    input logic                 exc_req,
    input logic                 pm_clear,
    input logic [NUM_LINES-1:0] mask_q,
    input logic [NUM_LINES-1:0] status_q,
    input logic                 pending_q
);
    localparam logic [NUM_LINES-1:0] BYP_MASK =
        {NUM_LINES{1'b1}} >> (NUM_LINES - NUM_BYPASS);

    // R4: a masked, non-bypass line never newly sets its status bit.
    a_r4_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q) & ~$past(mask_q) & ~BYP_MASK) == '0));

    // R5: the wake pulse follows an input that was high at the previous edge.
    a_r5_wake_source: assert property (@(posedge clk) disable iff (!rst_n)
        pm_clear |-> (|$past(irq_lines)));

    // R6/R7: no request goes out while interrupts are disabled.
    a_r6_req_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> ie_flag);

    // R7: a pending request is delivered as soon as the enable is high.
    a_r7_pending_delivered: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && ie_flag) |-> exc_req);

    // R7: a delivered pending request does not remain pending.
    a_r7_pending_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && ie_flag) |=> !pending_q);
endmodule

bind intc_wake_top intc_wake_chk #(.NUM_LINES(NUM_LINES), .NUM_BYPASS(NUM_BYPASS)) chk_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .ie_flag(ie_flag),
    .exc_req(exc_req), .pm_clear(pm_clear), .mask_q(mask_q),
    .status_q(status_q), .pending_q(pending_q)
);

// File: tb/intc_wake_top_tb_top.sv
`timescale 1ns/1ps
module intc_wake_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_lines = '0;
    logic        ie_flag = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        exc_req;
    logic        pm_clear;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    intc_wake_top dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .ie_flag(ie_flag),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .exc_req(exc_req), .pm_clear(pm_clear)
    );

    typedef struct packed {
        logic [4:0]  line;
        logic [31:0] mask;
        logic        ie;
        logic        exp_set;
        logic        exp_req;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{line: 5'd5,  mask: 32'h0000_0020, ie: 1'b1, exp_set: 1'b1, exp_req: 1'b1},
        '{line: 5'd5,  mask: 32'h0000_0000, ie: 1'b1, exp_set: 1'b0, exp_req: 1'b0},
        '{line: 5'd0,  mask: 32'h0000_0000, ie: 1'b1, exp_set: 1'b1, exp_req: 1'b1},
        '{line: 5'd1,  mask: 32'h0000_0000, ie: 1'b0, exp_set: 1'b1, exp_req: 1'b0},
        '{line: 5'd31, mask: 32'hFFFF_FFFF, ie: 1'b1, exp_set: 1'b1, exp_req: 1'b1},
        '{line: 5'd2,  mask: 32'hFFFF_FFFB, ie: 1'b1, exp_set: 1'b0, exp_req: 1'b0},
        '{line: 5'd17, mask: 32'h0002_0000, ie: 1'b0, exp_set: 1'b1, exp_req: 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Raise one line at a falling edge; return at the falling edge inside the
    // rise cycle (pulse visible) without advancing further.
    task automatic raise(input int ln);
        @(negedge clk);
        irq_lines[ln] = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1: state during reset
        rd(2'd0, d); chk("R1 mask", d, 0);
        chk("R1 exc_req", {31'd0, exc_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd0, d); chk("R1 mask", d, 0);
        rd(2'd1, d); chk("R1 prio", d, 0);
        rd(2'd2, d); chk("R1 status", d, 0);
        chk("R1 pm_clear", {31'd0, pm_clear}, 0);

        // R2/R10: register port and priority storage
        wr(2'd1, 32'hA5C3_0F96);
        rd(2'd1, d); chk("R10 prio readback", d, 32'hA5C3_0F96);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, d); chk("R2 addr3 reads zero", d, 0);
        rd(2'd0, d); chk("R2 addr3 write ignored mask", d, 0);
        rd(2'd1, d); chk("R2 addr3 write ignored prio", d, 32'hA5C3_0F96);

        // Table walk: R3 R4 R5 R6 R7
        foreach (VEC[k]) begin
            wr(2'd0, VEC[k].mask);
            rd(2'd0, d); chk("R2 mask readback", d, VEC[k].mask);
            ie_flag = VEC[k].ie;
            raise(int'(VEC[k].line));
            chk("R5 wake pulse", {31'd0, pm_clear}, 1);
            chk("R6 req in latch cycle", {31'd0, exc_req}, {31'd0, VEC[k].exp_req});
            @(negedge clk);
            chk("R5 wake single cycle", {31'd0, pm_clear}, 0);
            chk("R6 req single cycle", {31'd0, exc_req}, 0);
            rd(2'd2, d);
            chk("R4 status latch", d, VEC[k].exp_set ? (32'd1 << VEC[k].line) : 32'd0);
            irq_lines = '0;
            wr(2'd2, 32'd0);
            ie_flag = 1'b0;
            repeat (2) @(negedge clk);
        end

        // R7: pending request retried until enable rises
        wr(2'd0, 32'h0000_0008);
        ie_flag = 1'b0;
        raise(3);
        chk("R7 no req while disabled", {31'd0, exc_req}, 0);
        repeat (3) begin
            @(negedge clk);
            chk("R7 still held", {31'd0, exc_req}, 0);
        end
        ie_flag = 1'b1;
        #1 chk("R7 delivered on enable", {31'd0, exc_req}, 1);
        @(negedge clk);
        chk("R7 single delivery", {31'd0, exc_req}, 0);

        // R3: held line does not relatch after clear
        wr(2'd2, 32'd0);
        repeat (3) @(negedge clk);
        rd(2'd2, d); chk("R3 held line no relatch", d, 0);
        chk("R3 held no wake", {31'd0, pm_clear}, 0);
        irq_lines = '0;
        ie_flag = 1'b0;
        repeat (2) @(negedge clk);

        // R8: status write semantics
        wr(2'd0, 32'h0000_0030);
        raise(4); @(negedge clk);
        raise(5); @(negedge clk);
        rd(2'd2, d); chk("R8 two bits latched", d, 32'h30);
        wr(2'd2, 32'h0000_0010);
        rd(2'd2, d); chk("R8 zero clears", d, 32'h10);
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, d); chk("R8 ones cannot set", d, 32'h10);
        irq_lines = '0;
        repeat (3) @(negedge clk);
        // same-edge latch and clear
        @(negedge clk);
        irq_lines[5] = 1'b1;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'd0;
        @(negedge clk);
        reg_we = 1'b0;
        rd(2'd2, d); chk("R8 latch wins over clear", d, 32'h20);
        irq_lines = '0;

        // R9: full clear cancels pending
        wr(2'd2, 32'd0);
        wr(2'd0, 32'h0000_0040);
        ie_flag = 1'b0;
        raise(6); @(negedge clk);
        wr(2'd2, 32'd0);
        ie_flag = 1'b1;
        #1 chk("R9 pending cancelled", {31'd0, exc_req}, 0);
        irq_lines = '0;
        repeat (3) @(negedge clk);

        // R10: priority value does not change delivery
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'h0000_0200);
        raise(9);
        chk("R10 req unaffected by priority", {31'd0, exc_req}, 1);
        irq_lines = '0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule